// File: doc/BRIEF.md
# Recursive Sine-Cosine Oscillator

This block produces two sinusoidal sequences, one per output, from a coupled recurrence over two state registers. A single coefficient c, the cosine of the step angle, sets the frequency. Each step forms both new values from the previous pair through four fixed-point products and two sums. The block builds the companion coefficients c+1 and c−1 from c once, when a run is launched.

A run begins with a one-cycle start pulse. The pulse loads the initial pair, the coefficient and the number of steps. After that, every clock cycle with enable high commits one step and shows the new pair with a valid strobe. Once the requested number of steps is done, the block raises a done flag and ignores enable until the next start. Values are signed fixed point with three integer bits and sixteen fraction bits, so 1.0 is the code 65536.

Top module: `rsc_osc`

## Requirements
- R1: After reset, s1_out is 0, s2_out is 65536 (1.0), out_valid is 0 and done is 0.
- R2: On each step the new s1 is round(s1·c) + round(s2·(c+1)), computed from the pair held before the step.
- R3: On the same step the new s2 is round(s1·(c−1)) + round(s2·c), computed from the same old pair, and both registers change on the same edge.
- R4: Numbers are 20-bit two's complement with 16 fraction bits. A product is rounded by adding 32768 and shifting right arithmetically by 16, then clamped to [−524288, 524287]. The sum of two products is clamped to that same range.
- R5: A start pulse loads init_s1, init_s2, coef_c (and from it c+1 and c−1, each clamped) and num_steps. The loaded pair appears on the outputs on the next cycle with out_valid low. Start wins over enable, and a start during a run restarts it.
- R6: While a run is active, each cycle with enable high commits exactly one step, and out_valid is high in exactly those cycles that show a new pair. With enable low the pair holds.
- R7: After num_steps steps the run stops. done rises together with the final pair and stays high until the next start, and no further out_valid appears while enable stays high.
- R8: A start with num_steps equal to 0 sets done on the next cycle without any step, and the loaded pair stays on the outputs.
- R9: After reset and before any start, enable causes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads initial values, coefficient and step count; starts a run |
| enable | input | 1 | Commits one step per cycle while a run is active |
| init_s1 | input | 20 | Initial s1, Q3.16 |
| init_s2 | input | 20 | Initial s2, Q3.16 |
| coef_c | input | 20 | Coefficient c (cos θ), Q3.16 |
| num_steps | input | 8 | Number of steps in the run |
| s1_out | output | 20 | Current s1, Q3.16 |
| s2_out | output | 20 | Current s2, Q3.16 |
| out_valid | output | 1 | High for one cycle with each new pair |
| done | output | 1 | Run finished; holds until next start |

## Verification
The bench runs the nominal 50-step sequence with c = 0.9. A design that updates s2 from the already-updated s1 drifts away from the reference pairs within a step or two. Initial values near the top of the range force product and sum clamping, and a negative coefficient exercises rounding of negative products. Without clamping the outputs wrap in sign; with truncation in place of rounding they differ by one code. Further cases are enable bubbles, a restart in the middle of a run with enable held high, a zero-step run and extra enabled cycles after done. An off-by-one step counter would emit one pair too many or too few there, and a start that does not take priority would show an extra valid.

// File: rtl/rsc_osc_pkg.sv
package rsc_osc_pkg;

   // run phases of the oscillator controller
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } rsc_state_e;

endpackage

// File: rtl/rsc_osc_lane.sv
// One output lane: y = sat( sat(rnd(x0*k0)) + sat(rnd(x1*k1)) )
module rsc_osc_lane #(
   parameter int W             = 20,
   parameter int F             = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic signed [W-1:0] x0,
   input  logic signed [W-1:0] x1,
   input  logic signed [W-1:0] k0,
   input  logic signed [W-1:0] k1,
   output logic signed [W-1:0] y
);
   localparam int PW = 2 * W;
   localparam logic signed [PW-1:0] HALF = {{(PW-F){1'b0}}, 1'b1, {(F-1){1'b0}}};
   localparam logic signed [PW-1:0] MAXP = {{(W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [PW-1:0] MINP = {{(W+1){1'b1}}, {(W-1){1'b0}}};
   localparam logic signed [W:0]    MAXS = {2'b00, {(W-1){1'b1}}};
   localparam logic signed [W:0]    MINS = {2'b11, {(W-1){1'b0}}};

   logic signed [PW-1:0] p0, p1, r0, r1;
   logic signed [W-1:0]  q0, q1;
   logic signed [W:0]    sum;

   assign p0 = x0 * k0;
   assign p1 = x1 * k1;

   // rounding variant chosen at elaboration
   if (ROUND_NEAREST) begin : g_round
      assign r0 = (p0 + HALF) >>> F;
      assign r1 = (p1 + HALF) >>> F;
   end else begin : g_trunc
      assign r0 = p0 >>> F;
      assign r1 = p1 >>> F;
   end

   function automatic logic signed [W-1:0] clamp_p(input logic signed [PW-1:0] v);
      if (v > MAXP)      clamp_p = MAXP[W-1:0];
      else if (v < MINP) clamp_p = MINP[W-1:0];
      else               clamp_p = v[W-1:0];
   endfunction

   assign q0  = clamp_p(r0);
   assign q1  = clamp_p(r1);
   assign sum = {q0[W-1], q0} + {q1[W-1], q1};

   always_comb begin
      if (sum > MAXS)      y = MAXS[W-1:0];
      else if (sum < MINS) y = MINS[W-1:0];
      else                 y = sum[W-1:0];
   end

   // R4: two non-negative terms never clamp to a negative result
   always_comb begin
      if (!q0[W-1] && !q1[W-1])
         p_sat_sign_r4 : assert (!y[W-1]) else $error("lane sum wrapped negative");
   end
endmodule

// File: rtl/rsc_osc_ctrl.sv
module rsc_osc_ctrl
   import rsc_osc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             enable,
   input  logic [CNT_W-1:0] num_steps,
   output logic             load,
   output logic             step_en,
   output logic             out_valid,
   output logic             done
);
   rsc_state_e       state_q;
   logic [CNT_W-1:0] cnt_q, steps_q, cnt_nxt;
   logic             vld_q;

   assign load    = start;
   assign step_en = (state_q == ST_RUN) && enable && !start;
   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         steps_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= step_en;
         if (start) begin
            steps_q <= num_steps;
            cnt_q   <= '0;
            state_q <= (num_steps == '0) ? ST_DONE : ST_RUN;
         end else if (step_en) begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt == steps_q) state_q <= ST_DONE;
         end
      end
   end

   assign out_valid = vld_q;
   assign done      = (state_q == ST_DONE);

   // R7: counter never reaches the limit while still running
   p_cnt_bound_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (cnt_q < steps_q));
   // R7: done holds until a start arrives
   p_done_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   // R7: no further pairs once finished
   p_quiet_after_done_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !out_valid);
   // R6: a valid pair needs an enabled cycle without start
   p_valid_cause_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(enable) && !$past(start)));
endmodule

// File: rtl/rsc_osc.sv
module rsc_osc #(
   parameter int INT_BITS      = 3,
   parameter int FRAC_BITS     = 16,
   parameter int CNT_W         = 8,
   parameter int COEF_RESET    = 58982,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  start,
   input  logic                                  enable,
   input  logic signed [INT_BITS+FRAC_BITS:0]    init_s1,
   input  logic signed [INT_BITS+FRAC_BITS:0]    init_s2,
   input  logic signed [INT_BITS+FRAC_BITS:0]    coef_c,
   input  logic        [CNT_W-1:0]               num_steps,
   output logic signed [INT_BITS+FRAC_BITS:0]    s1_out,
   output logic signed [INT_BITS+FRAC_BITS:0]    s2_out,
   output logic                                  out_valid,
   output logic                                  done
);
   localparam int W = 1 + INT_BITS + FRAC_BITS;
   localparam logic signed [W:0]   ONE_X = {{(W-FRAC_BITS){1'b0}}, 1'b1, {FRAC_BITS{1'b0}}};
   localparam logic signed [W-1:0] ONE   = ONE_X[W-1:0];
   localparam logic signed [W:0]   MAXS  = {2'b00, {(W-1){1'b1}}};
   localparam logic signed [W:0]   MINS  = {2'b11, {(W-1){1'b0}}};
   localparam logic signed [W-1:0] C_RST = W'(COEF_RESET);

   // elaboration-time parameter checks
   if (INT_BITS < 2) begin : g_bad_int
      $error("INT_BITS must hold c+1");
   end
   if (FRAC_BITS < 2) begin : g_bad_frac
      $error("FRAC_BITS too small");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   function automatic logic signed [W-1:0] clamp_w(input logic signed [W:0] v);
      if (v > MAXS)      clamp_w = MAXS[W-1:0];
      else if (v < MINS) clamp_w = MINS[W-1:0];
      else               clamp_w = v[W-1:0];
   endfunction

   logic signed [W-1:0] s1_q, s2_q, c_q, cp_q, cm_q;
   logic signed [W-1:0] nxt [2];
   logic                load, step_en;

   rsc_osc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .enable    (enable),
      .num_steps (num_steps),
      .load      (load),
      .step_en   (step_en),
      .out_valid (out_valid),
      .done      (done)
   );

   // lane 0: s1*c + s2*(c+1); lane 1: s1*(c-1) + s2*c
   for (genvar i = 0; i < 2; i++) begin : g_lane
      rsc_osc_lane #(.W(W), .F(FRAC_BITS), .ROUND_NEAREST(ROUND_NEAREST)) u_lane (
         .x0 (s1_q),
         .x1 (s2_q),
         .k0 ((i == 0) ? c_q  : cm_q),
         .k1 ((i == 0) ? cp_q : c_q),
         .y  (nxt[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= '0;
         s2_q <= ONE;
         c_q  <= C_RST;
         cp_q <= clamp_w({C_RST[W-1], C_RST} + ONE_X);
         cm_q <= clamp_w({C_RST[W-1], C_RST} - ONE_X);
      end else if (load) begin
         s1_q <= init_s1;
         s2_q <= init_s2;
         c_q  <= coef_c;
         cp_q <= clamp_w({coef_c[W-1], coef_c} + ONE_X);
         cm_q <= clamp_w({coef_c[W-1], coef_c} - ONE_X);
      end else if (step_en) begin
         s1_q <= nxt[0];
         s2_q <= nxt[1];
      end
   end

   assign s1_out = s1_q;
   assign s2_out = s2_q;

   // R5: a start pulse puts the loaded pair on the outputs
   p_load_pair_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ((s1_q == $past(init_s1)) && (s2_q == $past(init_s2))));
   // R6: without a new pair and without a load, the pair holds
   p_hold_pair_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !$past(start)) |-> ($stable(s1_q) && $stable(s2_q)));
endmodule

// File: tb/rsc_osc_tb_top.sv
module rsc_osc_tb_top;
   localparam int W  = 20;
   localparam int CW = 8;
   localparam int MAXV = 524287;
   localparam int MINV = -524288;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic enable = 1'b0;
   logic signed [W-1:0] init_s1 = '0, init_s2 = '0, coef_c = '0;
   logic [CW-1:0] num_steps = '0;
   logic signed [W-1:0] s1_out, s2_out;
   logic out_valid, done;

   int n_chk = 0;
   int n_bad = 0;
   int q1[$];
   int q2[$];
   string tag1 = "R2";
   string tag2 = "R3";

   always #4 clk = ~clk;

   rsc_osc dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
      .init_s1(init_s1), .init_s2(init_s2), .coef_c(coef_c), .num_steps(num_steps),
      .s1_out(s1_out), .s2_out(s2_out), .out_valid(out_valid), .done(done)
   );

   function automatic int satw(longint v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return int'(v);
   endfunction

   function automatic int mulq(int a, int b);
      longint p;
      p = longint'(a) * longint'(b);
      p = (p + 64'sd32768) >>> 16;
      return satw(p);
   endfunction

   task automatic chk(string r, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   // monitor: scoreboard comparison 2 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && out_valid) begin
            if (q1.size() == 0) chk("R7 unexpected out_valid", 1, 0);
            else begin
               chk({tag1, " s1"}, int'(s1_out), q1.pop_front());
               chk({tag2, " s2"}, int'(s2_out), q2.pop_front());
            end
         end
      end
   end

   // driver: called at a falling edge; pushes the reference pairs, pulses start
   task automatic launch(int i1, int i2, int c, int n, bit en);
      int a, b, na, nb, cp, cm;
      cp = satw(longint'(c) + 65536);
      cm = satw(longint'(c) - 65536);
      a = i1; b = i2;
      for (int k = 0; k < n; k++) begin
         na = satw(longint'(mulq(a, c)) + longint'(mulq(b, cp)));
         nb = satw(longint'(mulq(a, cm)) + longint'(mulq(b, c)));
         q1.push_back(na); q2.push_back(nb);
         a = na; b = nb;
      end
      start = 1'b1; enable = en;
      init_s1 = W'(i1); init_s2 = W'(i2); coef_c = W'(c); num_steps = CW'(n);
      @(negedge clk);
      start = 1'b0;
      chk("R5 load s1", int'(s1_out), i1);
      chk("R5 load s2", int'(s2_out), i2);
      chk("R5 no valid on load", int'(out_valid), 0);
      chk("R8 done after load", int'(done), (n == 0) ? 1 : 0);
   endtask

   task automatic pump(int cycles, bit en);
      for (int k = 0; k < cycles; k++) begin
         enable = en;
         @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int h1, h2;
      repeat (3) @(negedge clk);
      chk("R1 reset s1", int'(s1_out), 0);
      chk("R1 reset s2", int'(s2_out), 65536);
      chk("R1 reset valid", int'(out_valid), 0);
      chk("R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: idle after reset
      pump(3, 1'b1);
      chk("R9 idle s1", int'(s1_out), 0);
      chk("R9 idle s2", int'(s2_out), 65536);
      enable = 1'b0;

      // nominal 50-step run, c = 0.9
      launch(0, 65536, 58982, 50, 1'b0);
      pump(50, 1'b1);
      chk("R7 done at end", int'(done), 1);
      chk("R7 all pairs seen", q1.size(), 0);
      h1 = int'(s1_out);
      pump(3, 1'b1);
      chk("R7 done holds", int'(done), 1);
      chk("R7 pair frozen", int'(s1_out), h1);

      // enable bubbles
      launch(0, 65536, 60000, 20, 1'b0);
      pump(5, 1'b1);
      h1 = int'(s1_out); h2 = int'(s2_out);
      pump(3, 1'b0);
      chk("R6 hold s1", int'(s1_out), h1);
      chk("R6 hold s2", int'(s2_out), h2);
      chk("R6 no valid idle", int'(out_valid), 0);
      pump(15, 1'b1);
      chk("R6 run finished", int'(done), 1);
      chk("R6 all pairs seen", q1.size(), 0);

      // restart mid-run with enable held high
      launch(65536, 0, 50000, 50, 1'b0);
      pump(10, 1'b1);
      chk("R5 not done mid-run", int'(done), 0);
      q1.delete(); q2.delete();
      launch(-30000, 40000, 20000, 7, 1'b1);
      pump(7, 1'b1);
      chk("R5 restart done", int'(done), 1);
      chk("R5 restart pairs seen", q1.size(), 0);

      // clamping and negative rounding
      tag1 = "R4"; tag2 = "R4";
      launch(458752, 458752, 58982, 4, 1'b0);
      pump(4, 1'b1);
      launch(-458752, 300000, -58982, 5, 1'b0);
      pump(5, 1'b1);
      launch(-3, 5, 32769, 3, 1'b0);
      pump(3, 1'b1);
      chk("R4 pairs seen", q1.size(), 0);
      tag1 = "R2"; tag2 = "R3";

      // zero-step run
      launch(1234, -5678, 58982, 0, 1'b0);
      pump(3, 1'b1);
      chk("R8 s1 kept", int'(s1_out), 1234);
      chk("R8 s2 kept", int'(s2_out), -5678);
      chk("R8 done held", int'(done), 1);

      enable = 1'b0;
      pump(2, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule